// File: doc/BRIEF.md
# Serial Channel Character Datapath and Interrupt Sources

This block is the character-level core of one asynchronous serial channel. On the transmit side it holds a single character written by the host and sends it out when the next character-time tick arrives. On the receive side, characters arriving from the line logic are queued in a small circular buffer, and one of them is moved into the receive data register on each character tick. Bit framing, parity and baud generation sit outside the block.

The block raises four request bits for a separate priority controller: receive, transmit-empty, modem status and error. The host chooses the receive request policy. It can be off, fire on every delivered character, or fire only on the first character after an arm command. Modem inputs (clear-to-send, carrier detect, ring) pass through a synchronizer, appear in the status image, and raise a status request on any edge when that request is enabled. The host clears pending requests with command pulses or with a channel reset.

Top module: `sio_chan_core`

## Requirements
- R1: After reset `stat_o` equals 8'h04 (only transmit-empty, bit 2, set), `irq_o` is 0 and `tx_valid_o` is low. Request bit order: bit 0 receive, bit 1 transmit, bit 2 modem status, bit 3 error.
- R2: When `tx_en_i` is low, a data write is dropped entirely: transmit-empty stays 1, the transmit request is unchanged, and no character goes out on later ticks.
- R3: An accepted data write clears transmit-empty (`stat_o[2]`) and the transmit request (`irq_o[1]`) one cycle later.
- R4: On a tick while a character is held, that character appears on `tx_data_o` with a one-cycle `tx_valid_o` pulse in the next cycle, and transmit-empty is set. If `tx_int_en_i` is high, `irq_o[1]` is set.
- R5: With `rx_int_mode_i` = 2'b00, delivered characters never set the receive request.
- R6: With `rx_int_mode_i` = 2'b01, a delivered character sets the receive request only if the arm command (`arm_rx_int_i`) came after the previous delivery. Every delivery disarms.
- R7: With `rx_int_mode_i` = 2'b10 or 2'b11, every delivered character sets the receive request.
- R8: When `rx_en_i` is low, a dequeued character is discarded. `rd_data_o`, receive-available and the arm flag are all left as they were.
- R9: A delivery sets receive-available (`stat_o[0]`) and loads `rd_data_o`. A read pulse (`rd_i`) clears receive-available and the receive request.
- R10: The receive queue has 16 slots and holds at most 15 characters. Pushes while it is full are dropped. Each tick delivers at most one character, oldest first.
- R11: Clear-to-send, ring and carrier detect appear in `stat_o` bits 5, 4 and 3 two clocks after they change. Any change sets `irq_o[2]` one clock later when `stat_int_en_i` is high.
- R12: `rx_err_i` sets the error request. `clr_tx_int_i`, `clr_stat_int_i` and `clr_err_int_i` clear their own request. `chan_reset_i` clears all requests, empties the transmit holder, sets transmit-empty and clears receive-available and the arm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit path enable |
| rx_en_i | input | 1 | Receive path enable |
| rx_int_mode_i | input | 2 | Receive request policy |
| tx_int_en_i | input | 1 | Transmit-empty request enable |
| stat_int_en_i | input | 1 | Modem status request enable |
| arm_rx_int_i | input | 1 | Arm first-character receive request |
| clr_tx_int_i | input | 1 | Clear transmit request |
| clr_stat_int_i | input | 1 | Clear status request |
| clr_err_int_i | input | 1 | Clear error request |
| chan_reset_i | input | 1 | Channel reset command |
| tick_i | input | 1 | Character-time tick |
| wr_valid_i | input | 1 | Host data write strobe |
| wr_data_i | input | 8 | Host write data |
| rd_i | input | 1 | Host data read strobe |
| rd_data_o | output | 8 | Receive data register |
| rx_push_i | input | 1 | Incoming character strobe |
| rx_push_data_i | input | 8 | Incoming character |
| rx_err_i | input | 1 | Receive error event |
| cts_i | input | 1 | Clear-to-send input |
| dcd_i | input | 1 | Carrier detect input |
| ri_i | input | 1 | Ring indicator input |
| tx_valid_o | output | 1 | Character sent pulse |
| tx_data_o | output | 8 | Sent character |
| stat_o | output | 8 | Status image |
| irq_o | output | 4 | Request bits to priority controller |

## Verification
The bench targets the first-character receive mode. Its arm flag must survive a discarded character while receive is disabled and must clear on any real delivery. A design that disarms on a dropped character, or never disarms, gives the wrong request on the next delivery. The bench also overfills the queue by two characters and expects exactly fifteen back, in order. An off-by-one full check would return sixteen or fourteen, or would drop the wrong ones. A write with transmit disabled must produce no character on the line, and a channel reset must discard a held character, so the scoreboard reports any unexpected transmit.

// File: rtl/sio_chan_pkg.sv
package sio_chan_pkg;
  typedef enum logic [1:0] {
    RXI_OFF   = 2'b00,
    RXI_FIRST = 2'b01,
    RXI_ALL_A = 2'b10,
    RXI_ALL_B = 2'b11
  } rx_int_mode_e;

  localparam int unsigned IRQ_RX   = 0;
  localparam int unsigned IRQ_TX   = 1;
  localparam int unsigned IRQ_STAT = 2;
  localparam int unsigned IRQ_ERR  = 3;
  localparam int unsigned IRQ_N    = 4;

  // status image bit positions
  localparam int unsigned ST_RXAV = 0;
  localparam int unsigned ST_TXE  = 2;
  localparam int unsigned ST_DCD  = 3;
  localparam int unsigned ST_RI   = 4;
  localparam int unsigned ST_CTS  = 5;
endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          tick_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          sent_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign sent_o  = tick_i & full_q & ~flush_i;
  assign full_o  = full_q;
  assign empty_o = ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q     <= 1'b0;
      data_q     <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= sent_o;
      if (sent_o) tx_data_o <= data_q;
      if (flush_i) begin
        full_q <= 1'b0;
      end else if (load_i) begin
        full_q <= 1'b1;
        data_q <= load_data_i;
      end else if (sent_o) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_rx_queue.sv
module sio_rx_queue #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              head_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  // one slot kept free: usable capacity is DEPTH-1
  assign do_push = push_i & (cnt_q != CW'(DEPTH-1));
  assign do_pop  = pop_i & (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= push_data_i;
  end
endmodule

// File: rtl/sio_modem_sync.sv
module sio_modem_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic         change_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign level_o  = stage_q[STAGES-1];
  assign change_o = |(stage_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/sio_irq_src.sv
module sio_irq_src #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  // clear has priority over set within a source
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_o[i] <= 1'b0;
      else if (flush_i || clr_i[i]) req_o[i] <= 1'b0;
      else if (set_i[i]) req_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sio_chan_core.sv
module sio_chan_core
  import sio_chan_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned Q_DEPTH  = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          rx_en_i,
  input  logic [1:0]    rx_int_mode_i,
  input  logic          tx_int_en_i,
  input  logic          stat_int_en_i,
  input  logic          arm_rx_int_i,
  input  logic          clr_tx_int_i,
  input  logic          clr_stat_int_i,
  input  logic          clr_err_int_i,
  input  logic          chan_reset_i,
  input  logic          tick_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_push_data_i,
  input  logic          rx_err_i,
  input  logic          cts_i,
  input  logic          dcd_i,
  input  logic          ri_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic [7:0]    stat_o,
  output logic [IRQ_N-1:0] irq_o
);
  localparam int unsigned CW = $clog2(Q_DEPTH+1);

  logic          wr_ok, tx_empty, hold_full, tx_sent;
  logic [DW-1:0] q_head;
  logic          q_empty, deliver;
  logic [CW-1:0] q_count;
  logic [2:0]    modem_lvl;
  logic          modem_chg;
  logic          rx_avail_q, armed_q;
  logic [DW-1:0] rx_data_q;
  logic          rx_req_set;
  logic [IRQ_N-1:0] irq_set, irq_clr;
  rx_int_mode_e  mode;

  assign mode  = rx_int_mode_e'(rx_int_mode_i);
  assign wr_ok = wr_valid_i & tx_en_i;

  sio_tx_hold #(.DW(DW)) u_tx (
    .clk_i, .rst_ni,
    .flush_i     (chan_reset_i),
    .load_i      (wr_ok),
    .load_data_i (wr_data_i),
    .tick_i,
    .empty_o     (tx_empty),
    .full_o      (hold_full),
    .sent_o      (tx_sent),
    .tx_valid_o,
    .tx_data_o
  );

  sio_rx_queue #(.DW(DW), .DEPTH(Q_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i      (rx_push_i),
    .push_data_i (rx_push_data_i),
    .pop_i       (tick_i),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .count_o     (q_count)
  );

  sio_modem_sync #(.N(3), .STAGES(SYNC_STG)) u_modem (
    .clk_i, .rst_ni,
    .async_i  ({cts_i, ri_i, dcd_i}),
    .level_o  (modem_lvl),
    .change_o (modem_chg)
  );

  // a dequeued character is only delivered when the receive path is on
  assign deliver = tick_i & ~q_empty & rx_en_i;

  always_comb begin
    unique case (mode)
      RXI_OFF:   rx_req_set = 1'b0;
      RXI_FIRST: rx_req_set = armed_q;
      default:   rx_req_set = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_avail_q <= 1'b0;
      rx_data_q  <= '0;
      armed_q    <= 1'b0;
    end else if (chan_reset_i) begin
      rx_avail_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      if (deliver) begin
        rx_data_q  <= q_head;
        rx_avail_q <= 1'b1;
      end else if (rd_i) begin
        rx_avail_q <= 1'b0;
      end
      if (arm_rx_int_i)  armed_q <= 1'b1;
      else if (deliver)  armed_q <= 1'b0;
    end
  end

  always_comb begin
    irq_set = '0;
    irq_clr = '0;
    irq_set[IRQ_RX]   = deliver & rx_req_set;
    irq_set[IRQ_TX]   = tx_sent & tx_int_en_i;
    irq_set[IRQ_STAT] = modem_chg & stat_int_en_i;
    irq_set[IRQ_ERR]  = rx_err_i;
    irq_clr[IRQ_RX]   = rd_i & ~deliver;
    irq_clr[IRQ_TX]   = wr_ok | clr_tx_int_i;
    irq_clr[IRQ_STAT] = clr_stat_int_i;
    irq_clr[IRQ_ERR]  = clr_err_int_i;
  end

  sio_irq_src #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni,
    .flush_i (chan_reset_i),
    .set_i   (irq_set),
    .clr_i   (irq_clr),
    .req_o   (irq_o)
  );

  always_comb begin
    stat_o          = '0;
    stat_o[ST_RXAV] = rx_avail_q;
    stat_o[ST_TXE]  = tx_empty;
    stat_o[ST_DCD]  = modem_lvl[0];
    stat_o[ST_RI]   = modem_lvl[1];
    stat_o[ST_CTS]  = modem_lvl[2];
  end

  assign rd_data_o = rx_data_q;
endmodule

// File: rtl/sio_chan_core_chk.sv
module sio_chan_core_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned Q_DEPTH = 16,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic          wr_valid_i,
  input logic          tick_i,
  input logic          chan_reset_i,
  input logic          rd_i,
  input logic [1:0]    rx_int_mode_i,
  input logic          tx_valid_o,
  input logic [7:0]    stat_o,
  input logic [3:0]    irq_o,
  input logic          hold_full,
  input logic [CW-1:0] q_count
);
  p_drop_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !tx_en_i && !tick_i && !chan_reset_i) |=> $stable(stat_o[2]));

  p_write_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && tx_en_i && !chan_reset_i) |=> (!stat_o[2] && !irq_o[1]));

  p_tick_sends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hold_full && !wr_valid_i && !chan_reset_i) |=> (tx_valid_o && stat_o[2]));

  p_rx_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_int_mode_i == 2'b00 && !irq_o[0]) |=> !irq_o[0]);

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !tick_i) |=> (!stat_o[0] && !irq_o[0]));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CW'(Q_DEPTH-1));
endmodule

bind sio_chan_core sio_chan_core_chk #(.DW(DW), .Q_DEPTH(Q_DEPTH), .CW($clog2(Q_DEPTH+1))) u_chk (
  .clk_i, .rst_ni, .tx_en_i, .wr_valid_i, .tick_i, .chan_reset_i, .rd_i,
  .rx_int_mode_i, .tx_valid_o, .stat_o, .irq_o,
  .hold_full(hold_full), .q_count(q_count)
);

// File: tb/sio_chan_core_test.sv
module sio_chan_core_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en = 0, rx_en = 0, tx_int_en = 0, stat_int_en = 0;
  logic [1:0] rx_mode = 2'b00;
  logic arm = 0, clr_tx = 0, clr_stat = 0, clr_err = 0, creset = 0;
  logic tick = 0, wr = 0, rd = 0, push = 0, rx_err = 0;
  logic [7:0] wdata = 0, pdata = 0;
  logic cts = 0, dcd = 0, ri = 0;
  logic [7:0] rd_data, tx_data, stat;
  logic tx_valid;
  logic [3:0] irq;

  int total = 0, bad = 0;
  logic [7:0] exp_q [$];
  bit done = 0;

  always #2.5 clk = ~clk;

  sio_chan_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .rx_int_mode_i(rx_mode), .tx_int_en_i(tx_int_en), .stat_int_en_i(stat_int_en),
    .arm_rx_int_i(arm), .clr_tx_int_i(clr_tx), .clr_stat_int_i(clr_stat),
    .clr_err_int_i(clr_err), .chan_reset_i(creset), .tick_i(tick),
    .wr_valid_i(wr), .wr_data_i(wdata), .rd_i(rd), .rd_data_o(rd_data),
    .rx_push_i(push), .rx_push_data_i(pdata), .rx_err_i(rx_err),
    .cts_i(cts), .dcd_i(dcd), .ri_i(ri),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .stat_o(stat), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every transmitted character must be expected (R2, R4)
  always @(negedge clk) begin
    if (rst_ni && tx_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected tx act=%0h exp=none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          bad++;
          $display("FAIL R4 tx data act=%0h exp=%0h", tx_data, e);
        end
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1; cyc(); tick = 0;
  endtask

  task automatic host_wr(logic [7:0] d, bit expect_sent);
    wr = 1; wdata = d; cyc(); wr = 0;
    if (expect_sent) exp_q.push_back(d);
  endtask

  task automatic host_rd();
    rd = 1; cyc(); rd = 0;
  endtask

  task automatic line_push(logic [7:0] d);
    push = 1; pdata = d; cyc(); push = 0;
  endtask

  task automatic one(ref logic s);
    s = 1; cyc(); s = 0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc();
    // R1 reset state
    check("R1 stat", stat, 8'h04);
    check("R1 irq", irq, 4'h0);
    check("R1 tx_valid", tx_valid, 0);

    // R2 dropped write
    host_wr(8'h11, 0);
    check("R2 txe after drop", stat[2], 1);
    pulse_tick(); cyc();
    check("R2 txe after tick", stat[2], 1);
    check("R2 no tx irq", irq[1], 0);

    // R3 / R4 transmit
    tx_en = 1; tx_int_en = 1;
    host_wr(8'hA5, 1);
    check("R3 txe cleared", stat[2], 0);
    check("R3 tx irq clear", irq[1], 0);
    pulse_tick();
    check("R4 txe set", stat[2], 1);
    check("R4 tx irq set", irq[1], 1);
    host_wr(8'h3C, 1);
    check("R3 write clears pending tx irq", irq[1], 0);
    pulse_tick(); cyc();
    check("R4 tx irq again", irq[1], 1);
    one(clr_tx);
    check("R12 clr tx irq", irq[1], 0);
    tx_int_en = 0;
    host_wr(8'h5A, 1);
    pulse_tick(); cyc();
    check("R4 no tx irq when disabled", irq[1], 0);

    // R5 mode off
    rx_en = 1; rx_mode = 2'b00;
    line_push(8'h55);
    pulse_tick();
    check("R9 avail", stat[0], 1);
    check("R9 data", rd_data, 8'h55);
    check("R5 no rx irq", irq[0], 0);
    host_rd();
    check("R9 avail cleared", stat[0], 0);

    // R7 every char
    rx_mode = 2'b10;
    line_push(8'h61); line_push(8'h62);
    pulse_tick();
    check("R7 irq first", irq[0], 1);
    check("R7 data first", rd_data, 8'h61);
    host_rd();
    check("R9 rx irq cleared", irq[0], 0);
    pulse_tick();
    check("R7 irq second", irq[0], 1);
    check("R7 data second", rd_data, 8'h62);
    host_rd();
    rx_mode = 2'b11;
    line_push(8'h63); pulse_tick();
    check("R7 mode 11 irq", irq[0], 1);
    host_rd();

    // R6 first-character mode
    rx_mode = 2'b01;
    line_push(8'h70); pulse_tick();
    check("R6 unarmed no irq", irq[0], 0);
    check("R6 unarmed avail", stat[0], 1);
    host_rd();
    one(arm);
    line_push(8'h71); line_push(8'h72);
    pulse_tick();
    check("R6 armed irq", irq[0], 1);
    host_rd();
    pulse_tick();
    check("R6 disarmed no irq", irq[0], 0);
    check("R6 second data", rd_data, 8'h72);
    host_rd();

    // R8 receive disabled
    one(arm);
    rx_en = 0;
    line_push(8'h77); pulse_tick();
    check("R8 avail unchanged", stat[0], 0);
    check("R8 data unchanged", rd_data, 8'h72);
    check("R8 no irq", irq[0], 0);
    rx_en = 1;
    line_push(8'h78); pulse_tick();
    check("R8 arm kept", irq[0], 1);
    check("R8 next data", rd_data, 8'h78);
    host_rd();

    // R10 queue capacity and order
    rx_mode = 2'b00;
    push = 1;
    for (int i = 0; i < 17; i++) begin
      pdata = 8'h80 + 8'(i); cyc();
    end
    push = 0;
    for (int i = 0; i < 15; i++) begin
      pulse_tick();
      check("R10 avail", stat[0], 1);
      check("R10 order", rd_data, 8'h80 + 32'(i));
      host_rd();
    end
    pulse_tick();
    check("R10 only 15 kept", stat[0], 0);
    check("R10 data held", rd_data, 8'h8E);

    // R11 modem lines
    stat_int_en = 1;
    cts = 1; cyc(2);
    check("R11 cts mirror", stat[5], 1);
    cyc();
    check("R11 stat irq", irq[2], 1);
    one(clr_stat);
    check("R12 clr stat", irq[2], 0);
    dcd = 1; cyc(4);
    check("R11 dcd mirror", stat[3], 1);
    check("R11 dcd irq", irq[2], 1);
    one(clr_stat);
    ri = 1; cyc(4);
    check("R11 ri mirror", stat[4], 1);
    check("R11 ri irq", irq[2], 1);
    one(clr_stat);
    stat_int_en = 0;
    cts = 0; cyc(4);
    check("R11 cts low", stat[5], 0);
    check("R11 no irq disabled", irq[2], 0);

    // R12 error and channel reset
    one(rx_err);
    check("R12 err irq", irq[3], 1);
    one(clr_err);
    check("R12 err clr", irq[3], 0);
    rx_mode = 2'b10;
    line_push(8'h99); pulse_tick();
    host_wr(8'h42, 0);
    one(rx_err);
    one(creset);
    check("R12 reset irq", irq, 4'h0);
    check("R12 reset txe", stat[2], 1);
    check("R12 reset avail", stat[0], 0);
    pulse_tick(); cyc(2);
    check("R12 scoreboard empty", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule